// File: doc/BRIEF.md
# I2C Target Address Front End with General Call

This block is the receive side of an I2C target. A fast system clock oversamples SCL and SDA, and the block finds START, repeated START and STOP conditions. It shifts in the address byte after every START and compares the top seven bits with the device's own address. When they match, it acknowledges by pulling SDA low. For a write, each following byte goes out as a single-cycle strobe toward a register file. The block never stretches the clock.

The own address has two parts. The upper five bits are a fixed prefix set by a parameter. The lower two bits are a code taken from two strap pins. The straps are captured only while reset is held and when a general call command asks for it, and they are ignored at all other times. A general call (address 0000000 with the write bit) is acknowledged, and the next byte is read as a command. Command 04h captures the straps again. Command 06h captures the straps again and also sends a one-cycle reset pulse to the registers.

Top module: `i2c_gc_target`

## Requirements
- R1: While reset is low, and in the first cycles after it is released, SDA is not pulled, no strobe is raised, and the strap code output equals the strap inputs as they were at reset release.
- R2: A START seen while a transfer is in progress (repeated START) restarts address reception at once, without a STOP first.
- R3: Bits are sampled on SCL rising edges, MSB first. If the address byte's upper seven bits equal the prefix (default 10010b) followed by the latched strap code {strap[1], strap[0]}, SDA is pulled low during the ninth SCL clock, and `addr_hit_o` pulses with `dir_o` set to the eighth bit. SDA is pulled only while SCL is low at the start of the pull and only in an acknowledge slot.
- R4: After an address that does not match, SDA stays released, and no byte or hit strobe is raised, until the next START.
- R5: After a matched write address (eighth bit 0), each following byte is acknowledged and appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse.
- R6: After a matched read address (eighth bit 1), the address is acknowledged, and the block then neither drives SDA nor raises `rx_valid_o` until the next START or STOP.
- R7: Address byte 00h (general call, write) is acknowledged, and so is the command byte after it.
- R8: General call command 04h loads the strap inputs into the strap code and raises no register reset.
- R9: General call command 06h loads the strap inputs into the strap code and raises `reg_rst_o` for exactly one cycle.
- R10: Any other general call command byte is acknowledged, but it changes neither the strap code nor `reg_rst_o`.
- R11: Outside reset and the 04h/06h commands, changes on the strap inputs affect neither the strap code nor the address the block answers to.
- R12: A STOP releases SDA and returns the block to idle. SCL clocks that come later without a START are not acknowledged and produce no strobes.
- R13: Address byte 01h (general call with the read bit) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 2 | Address strap pins |
| strap_code_o | output | 2 | Currently latched strap code |
| addr_hit_o | output | 1 | One-cycle pulse when the own address is acknowledged |
| dir_o | output | 1 | Direction bit of the last matched address (1 = read) |
| rx_data_o | output | 8 | Last received write data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| reg_rst_o | output | 1 | One-cycle register reset from general call 06h |

## Verification
The assertions check these properties on every cycle: `rx_valid_o` and `reg_rst_o` are single-cycle pulses, the strap code stays put unless a latch command was decoded, the SDA pull starts only while the synchronized SCL is low, and a STOP always releases SDA. The bench scenarios are needed to show which addresses are acknowledged, that bytes arrive intact, that read and mismatched transfers are silent, that repeated START restarts address reception, that the three kinds of general call command behave differently, and that clocks after a STOP are ignored. Random transfer mixes, each with or without a closing STOP, exercise these paths in many orders.

// File: rtl/i2c_gc_pkg.sv
// Shared types and constants for the I2C general-call target.
// Assumes 8-bit I2C bytes; the state encoding is internal to the controller.
package i2c_gc_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] GC_CMD_LATCH = 8'h04;
    localparam logic [BYTE_W-1:0] GC_CMD_RESET = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_SKIP
    } tgt_state_t;

    typedef enum logic [1:0] {
        MODE_WRITE,
        MODE_READ,
        MODE_GCALL
    } tgt_mode_t;

endpackage

// File: rtl/i2c_gc_bus_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives the bus
// events from the synchronized levels: SCL edges, START (SDA falls while SCL
// is high) and STOP (SDA rises while SCL is high).
// Assumes the system clock runs several times faster than SCL.
module i2c_gc_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;
    localparam int DEPTH = STAGES + 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] pipe;

        // Shift the line through the synchronizer plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[DEPTH-2:0], raw[g]};
        end

        assign cur[g]  = pipe[STAGES-1];
        assign prev[g] = pipe[STAGES];
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  = cur[0] & ~prev[0];
    assign scl_fall  = ~cur[0] & prev[0];
    assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];

endmodule

// File: rtl/i2c_gc_strap_latch.sv
// Holds the strap code used as the low address bits. It samples the straps
// while reset is asserted and when the controller requests a relatch;
// otherwise the code is frozen. Assumes the straps are stable when sampled.
module i2c_gc_strap_latch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         relatch,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] code_o
);

    // Capture straps during reset and on a relatch request only.
    always_ff @(posedge clk) begin
        if (!rst_n || relatch) code_o <= strap_i;
    end

endmodule

// File: rtl/i2c_gc_ctrl.sv
// Byte-level controller: address compare, general call command decode,
// write-byte strobes and ACK drive. Bits are taken on SCL rising edges; the
// ACK pull starts on the falling edge after the eighth bit and ends on the
// falling edge of the ninth clock. START and STOP override any state.
module i2c_gc_ctrl
    import i2c_gc_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull,
    output logic              addr_hit,
    output logic              dir,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              gc_latch,
    output logic              reg_rst
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_t        state;
    tgt_mode_t         mode;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;

    assign byte_done = scl_fall && (cnt == FULL);

    // Main sequencer: bus conditions, bit shifting, byte decisions, ACK slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode     <= MODE_WRITE;
            cnt      <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            addr_hit <= 1'b0;
            dir      <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            gc_latch <= 1'b0;
            reg_rst  <= 1'b0;
        end else begin
            addr_hit <= 1'b0;
            rx_valid <= 1'b0;
            gc_latch <= 1'b0;
            reg_rst  <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_det) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA, ST_CMD: begin
                        if (scl_rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (byte_done) begin
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == own_addr) begin
                                    sda_pull <= 1'b1;
                                    addr_hit <= 1'b1;
                                    dir      <= shreg[0];
                                    mode     <= shreg[0] ? MODE_READ : MODE_WRITE;
                                    state    <= ST_ADDR_ACK;
                                end else if (shreg == '0) begin
                                    sda_pull <= 1'b1;
                                    mode     <= MODE_GCALL;
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state    <= ST_SKIP;
                                end
                            end else if (state == ST_DATA) begin
                                rx_data  <= shreg;
                                rx_valid <= 1'b1;
                                sda_pull <= 1'b1;
                                state    <= ST_DATA_ACK;
                            end else begin
                                gc_latch <= (shreg == GC_CMD_LATCH) || (shreg == GC_CMD_RESET);
                                reg_rst  <= (shreg == GC_CMD_RESET);
                                sda_pull <= 1'b1;
                                state    <= ST_CMD_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK, ST_CMD_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            if (state == ST_ADDR_ACK) begin
                                case (mode)
                                    MODE_WRITE: state <= ST_DATA;
                                    MODE_GCALL: state <= ST_CMD;
                                    default:    state <= ST_SKIP;
                                endcase
                            end else if (state == ST_DATA_ACK) begin
                                state <= ST_DATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_gc_target.sv
// Top level of the I2C general-call target: synchronizer, strap latch and
// byte controller. The own address is ADDR_PREFIX followed by the latched
// strap code. SDA is open drain: sda_pull_o = 1 pulls the line low.
module i2c_gc_target #(
    parameter int            STRAP_W     = 2,
    parameter int            PREFIX_W    = 5,
    parameter logic [4:0]    ADDR_PREFIX = 5'b10010,
    parameter int            SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [STRAP_W-1:0] strap_code_o,
    output logic               addr_hit_o,
    output logic               dir_o,
    output logic [7:0]         rx_data_o,
    output logic               rx_valid_o,
    output logic               reg_rst_o
);

    localparam int ADDR_W = PREFIX_W + STRAP_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic gc_latch;
    logic [ADDR_W-1:0] own_addr;

    i2c_gc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_gc_strap_latch #(.W(STRAP_W)) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .relatch (gc_latch),
        .strap_i (strap_i),
        .code_o  (strap_code_o)
    );

    assign own_addr = {ADDR_PREFIX[PREFIX_W-1:0], strap_code_o};

    i2c_gc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .sda_pull  (sda_pull_o),
        .addr_hit  (addr_hit_o),
        .dir       (dir_o),
        .rx_data   (rx_data_o),
        .rx_valid  (rx_valid_o),
        .gc_latch  (gc_latch),
        .reg_rst   (reg_rst_o)
    );

endmodule

// File: rtl/i2c_gc_checker.sv
// Cycle-level properties of i2c_gc_target, bound to every instance.
module i2c_gc_checker #(
    parameter int STRAP_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sda_pull,
    input logic               rx_valid,
    input logic               reg_rst,
    input logic               scl_s,
    input logic               stop_det,
    input logic               gc_latch,
    input logic [STRAP_W-1:0] strap_code
);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_reset_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst |=> !reg_rst);

    p_strap_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !gc_latch |=> $stable(strap_code));

    p_ack_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

endmodule

bind i2c_gc_target i2c_gc_checker #(.STRAP_W(STRAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull   (sda_pull_o),
    .rx_valid   (rx_valid_o),
    .reg_rst    (reg_rst_o),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .gc_latch   (gc_latch),
    .strap_code (strap_code_o)
);

// File: tb/tb_i2c_gc_target.sv
module tb_i2c_gc_target;

    localparam int       T      = 10;
    localparam logic [4:0] PREFIX = 5'b10010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_line;
    logic sda_pull, addr_hit, dir, rx_valid, reg_rst;
    logic [1:0] code;
    logic [7:0] rx_data;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2c_gc_target dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .sda_pull_o   (sda_pull),
        .strap_i      (strap),
        .strap_code_o (code),
        .addr_hit_o   (addr_hit),
        .dir_o        (dir),
        .rx_data_o    (rx_data),
        .rx_valid_o   (rx_valid),
        .reg_rst_o    (reg_rst)
    );

    int checks = 0, errors = 0;
    int hit_n = 0, rx_n = 0, rst_cnt = 0, stray = 0;
    logic last_dir = 1'b0;
    logic [7:0] rx_last = '0;
    logic ack_win = 1'b0;
    logic [1:0] latched = 2'b10;
    bit done = 0;

    // Observe the strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_hit) begin hit_n++; last_dir = dir; end
            if (rx_valid) begin rx_n++; rx_last = rx_data; end
            if (reg_rst) rst_cnt++;
            if (sda_pull && !ack_win) stray++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] own_of(input logic [1:0] c);
        return {PREFIX, c};
    endfunction

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b0; wt(T);
        m_scl = 1'b0; wt(T);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(T);
        m_scl = 1'b1; wt(T);
        m_sda = 1'b1; wt(T);
    endtask

    // Eight bits MSB first, then a released ninth clock; reports the ACK seen.
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(T);
            m_scl = 1'b1; wt(2 * T);
            m_scl = 1'b0;
            if (i == 0) ack_win = 1'b1;
            wt(T);
        end
        m_sda = 1'b1; wt(T);
        m_scl = 1'b1; wt(T);
        acked = sda_pull;
        wt(T);
        m_scl = 1'b0; wt(T);
        ack_win = 1'b0;
    endtask

    task automatic own_write(input int nbytes, input bit with_stop);
        bit a;
        int h0 = hit_n;
        bus_start();
        send_byte({own_of(latched), 1'b0}, a);
        chk(a, "R3 own write address ack", a, 1);
        chk(hit_n == h0 + 1 && last_dir == 1'b0, "R3 hit strobe dir=0", hit_n - h0, 1);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] d = 8'($urandom);
            int r0 = rx_n;
            send_byte(d, a);
            chk(a, "R5 data byte ack", a, 1);
            chk(rx_n == r0 + 1 && rx_last == d, "R5 received byte", rx_last, d);
        end
        if (with_stop) bus_stop();
    endtask

    task automatic gcall(input logic [7:0] cmd);
        bit a;
        bus_start();
        send_byte(8'h00, a);
        chk(a, "R7 general call address ack", a, 1);
        send_byte(cmd, a);
        chk(a, "R7 general call command ack", a, 1);
        bus_stop();
    endtask

    initial begin
        bit a;
        int h0, r0, c0;
        void'($urandom(32'd20240611));
        wt(5);
        chk(sda_pull == 1'b0 && rx_valid == 1'b0, "R1 reset outputs idle", sda_pull, 0);
        rst_n = 1'b1;
        wt(3);
        chk(code == 2'b10, "R1 strap code from reset", code, 2);
        chk(sda_pull == 1'b0, "R1 SDA released after reset", sda_pull, 0);

        // Directed own write.
        own_write(3, 1'b1);

        // Random mix of transfers, with and without STOP.
        for (int t = 0; t < 24; t++) begin
            int kind = int'($urandom % 3);
            bit stp = bit'($urandom % 2);
            if (kind == 0) begin
                own_write(1 + int'($urandom % 3), stp);
            end else if (kind == 1) begin
                logic [6:0] ad;
                do ad = 7'($urandom); while (ad == own_of(latched) || ad == 7'd0);
                h0 = hit_n; r0 = rx_n;
                bus_start();
                send_byte({ad, 1'($urandom)}, a);
                chk(!a, "R4 mismatched address not acked", a, 0);
                send_byte(8'($urandom), a);
                chk(!a && hit_n == h0 && rx_n == r0, "R4 silent after mismatch", a, 0);
                if (stp) bus_stop();
            end else begin
                h0 = hit_n; r0 = rx_n;
                bus_start();
                send_byte({own_of(latched), 1'b1}, a);
                chk(a && hit_n == h0 + 1 && last_dir == 1'b1, "R6 read address ack dir=1", a, 1);
                send_byte(8'hFF, a);
                chk(!a && rx_n == r0, "R6 no drive in read data", a, 0);
                if (stp) bus_stop();
            end
        end
        bus_stop();

        // R2: mismatch then repeated START to own address.
        bus_start();
        send_byte({~own_of(latched), 1'b0}, a);
        chk(!a, "R2 first address mismatched", a, 0);
        own_write(1, 1'b1);

        // R11: strap change without a command is ignored.
        strap = 2'b01;
        wt(T);
        chk(code == 2'b10, "R11 strap code frozen", code, 2);
        bus_start();
        send_byte({own_of(2'b01), 1'b0}, a);
        chk(!a, "R11 new strap address ignored", a, 0);
        bus_stop();
        own_write(1, 1'b1);

        // R8: command 04h relatch without reset.
        c0 = rst_cnt;
        gcall(8'h04);
        latched = 2'b01;
        chk(code == 2'b01, "R8 strap relatched by 04h", code, 1);
        chk(rst_cnt == c0, "R8 no register reset", rst_cnt - c0, 0);
        own_write(2, 1'b1);

        // R9: command 06h relatch with reset.
        strap = 2'b11;
        c0 = rst_cnt;
        gcall(8'h06);
        latched = 2'b11;
        chk(code == 2'b11, "R9 strap relatched by 06h", code, 3);
        chk(rst_cnt == c0 + 1, "R9 one register reset", rst_cnt - c0, 1);
        own_write(1, 1'b1);

        // R10: other command has no effect.
        strap = 2'b00;
        c0 = rst_cnt;
        gcall(8'h5A);
        chk(code == 2'b11, "R10 strap unchanged by other command", code, 3);
        chk(rst_cnt == c0, "R10 no reset by other command", rst_cnt - c0, 0);

        // R13: general call with read bit.
        bus_start();
        send_byte(8'h01, a);
        chk(!a, "R13 general call read not acked", a, 0);
        bus_stop();

        // R12: clocks after STOP without START are ignored.
        h0 = hit_n; r0 = rx_n;
        own_write(1, 1'b1);
        h0 = hit_n; r0 = rx_n;
        send_byte({own_of(latched), 1'b0}, a);
        chk(!a && hit_n == h0, "R12 no ack without START", a, 0);
        send_byte(8'h3C, a);
        chk(!a && rx_n == r0, "R12 no byte without START", rx_n - r0, 0);
        chk(sda_pull == 1'b0, "R12 SDA released when idle", sda_pull, 0);

        chk(stray == 0, "R3 SDA pulled only in ACK slots", stray, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule